// File: doc/BRIEF.md
# Strip Hit Cluster Compressor

This block turns one snapshot of 256 binary strip hits (two rows of 128 strips, numbered 0 to 255 as one address space) into a fixed-size 51-bit cluster summary ready for readout. A one-cycle `start` pulse captures the hit vector together with the mode select and the event's trigger and bunch identifiers. The block then walks the strips one per clock, from strip 255 down to strip 0, and raises `valid` for one cycle when the summary is ready.

Two encodings are offered. The fast encoding keeps up to four clusters, each reduced to the address of its middle strip. The full encoding keeps up to three clusters, each given as the address of its first (highest) strip plus a 3-bit picture of the three strips below it. When more clusters exist than slots, the first ones found are kept and an overflow bit is set.

Top module: `strip_cluster_compressor`

## Requirements
- R1: After reset `valid` is 0 and `payload` is all zeros.
- R2: A `start` sampled while idle is accepted; `valid` is high for exactly one cycle, on the 257th rising edge after the accepting edge, and `payload` holds its value until the next `valid`.
- R3: A `start` that arrives while a scan is running is ignored: it produces no extra `valid` pulse and does not change the result of the running scan.
- R4: Payload layout: bit 50 is the mode (1 = full), bits 49:42 the trigger ID, bits 41:34 the bunch ID, bit 33 the overflow flag, bits 32:0 the cluster field.
- R5: Fast mode (`full_mode` = 0): a cluster is a run of consecutive hit strips from `hi` down to `lo`; its reported address is floor((hi+lo)/2). Slots sit at bits 31:24, 23:16, 15:8, 7:0, the highest cluster in 31:24; bit 32 is 0.
- R6: Full mode (`full_mode` = 1): the highest hit strip s not yet consumed opens a cluster; its 11-bit slot is {s, pattern} where pattern bit 2, 1, 0 are the hits of strips s-1, s-2, s-3; strips s..s-3 are then consumed. Slots sit at bits 32:22, 21:11, 10:0, the highest cluster first.
- R7: Slots with no cluster read all ones (8'hFF in fast mode, 11'h7FF in full mode) and the overflow flag stays 0 when all clusters fit.
- R8: When clusters outnumber the slots (more than 4 in fast mode, more than 3 in full mode) the overflow flag is 1 and the slots hold the first clusters found.
- R9: A run that touches strip 255 or strip 0 is reported like any other; strips below 0 read as not hit in a full-mode pattern.
- R10: Hits, mode, trigger ID and bunch ID are taken only at the accepting edge; changes while the scan runs have no effect on the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan of the present inputs |
| full_mode | input | 1 | 0 = fast (centre) encoding, 1 = full (address plus pattern) encoding |
| hits | input | 256 | Strip hit vector, bit n = strip n |
| trig_id | input | 8 | Trigger identifier of the event |
| bunch_id | input | 8 | Bunch identifier of the event |
| valid | output | 1 | One-cycle strobe: payload is new |
| payload | output | 51 | Compressed cluster summary |

## Verification
The two functions that can meet in one cycle are the delivery of a finished summary and the acceptance of the next event: a `start` driven in the very cycle `valid` is high must begin a new scan while the delivered payload stays intact, and the second summary must arrive 257 edges later. The bench provokes this with back-to-back events of different modes and compares both payloads against its own model. A second meeting point, a run closing at strip 0 in the same step that ends the scan, is provoked with hits on strips 1 and 0 and judged by the last slot.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int STRIPS     = 256;
  localparam int ADDR_W     = $clog2(STRIPS);
  localparam int PAT_W      = 3;
  localparam int SLOT_W     = ADDR_W + PAT_W;
  localparam int FAST_SLOTS = 4;
  localparam int FULL_SLOTS = 3;
  localparam int MAX_SLOTS  = (FAST_SLOTS > FULL_SLOTS) ? FAST_SLOTS : FULL_SLOTS;
  localparam int CNT_W      = $clog2(MAX_SLOTS + 1);
  localparam int FAST_FW    = FAST_SLOTS * ADDR_W;
  localparam int FULL_FW    = FULL_SLOTS * SLOT_W;
  localparam int FIELD_W    = (FAST_FW > FULL_FW) ? FAST_FW : FULL_FW;

  // Middle strip of a run, rounded towards the lower address.
  function automatic logic [ADDR_W-1:0] run_centre(input logic [ADDR_W-1:0] hi,
                                                   input logic [ADDR_W-1:0] lo);
    logic [ADDR_W:0] sum;
    sum = {1'b0, hi} + {1'b0, lo};
    return sum[ADDR_W:1];
  endfunction

  // Number of slots available in a given mode.
  function automatic logic [CNT_W-1:0] slot_limit(input logic full);
    return full ? CNT_W'(FULL_SLOTS) : CNT_W'(FAST_SLOTS);
  endfunction
endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scc_pkg::*;
#(
  parameter int NSTRIP = STRIPS,
  localparam int AW = $clog2(NSTRIP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          step,
  output logic          finish,
  output logic [AW-1:0] idx
);
  logic busy;
  logic last_step;

  assign accept    = start && !busy;
  assign step      = busy;
  assign last_step = busy && (idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      finish <= 1'b0;
      idx    <= '0;
    end else begin
      finish <= last_step;
      if (accept) begin
        busy <= 1'b1;
        idx  <= AW'(NSTRIP - 1);
      end else if (last_step) begin
        busy <= 1'b0;
      end else if (busy) begin
        idx <= idx - 1'b1;
      end
    end
  end

  // R3: a start during a scan must not restart the strip index
  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && idx != '0) |=> (busy && idx == $past(idx) - 1'b1));

  // R2: the scan always ends with exactly one finish step
  assert_finish_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish);
endmodule

// File: rtl/run_scanner.sv
module run_scanner
  import scc_pkg::*;
#(
  parameter int NSTRIP = STRIPS,
  localparam int AW = $clog2(NSTRIP),
  localparam int SW = AW + PAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             full_mode,
  input  logic [AW-1:0]    idx,
  input  logic             cur,
  input  logic [PAT_W-1:0] nbr,
  output logic             emit,
  output logic [SW-1:0]    word
);
  logic          in_run;
  logic [AW-1:0] run_hi;
  logic [1:0]    skip;

  logic          close_mid, close_end, fast_emit, full_emit;
  logic [AW-1:0] hi_sel, lo_sel, fast_addr;

  assign close_mid = in_run && !cur;
  assign close_end = cur && (idx == '0);
  assign fast_emit = close_mid || close_end;
  assign hi_sel    = in_run ? run_hi : idx;
  assign lo_sel    = close_mid ? (idx + {{(AW-1){1'b0}}, 1'b1}) : '0;
  assign fast_addr = run_centre(hi_sel, lo_sel);
  assign full_emit = cur && (skip == 2'd0);

  assign emit = step && (full_mode ? full_emit : fast_emit);
  assign word = full_mode ? {idx, nbr} : {fast_addr, {PAT_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      in_run <= 1'b0;
      run_hi <= '0;
      skip   <= 2'd0;
    end else if (step) begin
      if (!full_mode) begin
        if (cur && !in_run && idx != '0) begin
          in_run <= 1'b1;
          run_hi <= idx;
        end else if (fast_emit) begin
          in_run <= 1'b0;
        end
      end else begin
        if (full_emit)          skip <= 2'd3;
        else if (skip != 2'd0)  skip <= skip - 2'd1;
      end
    end
  end

  // R6: a full-mode cluster consumes the next strip, so no emit follows at once
  assert_full_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && full_mode && !clear) |=> !emit);

  // R5: a fast-mode cluster is reported only once its run has ended
  assert_fast_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !full_mode && idx != '0) |-> $past(step && cur));
endmodule

// File: rtl/slot_collector.sv
module slot_collector
  import scc_pkg::*;
#(
  parameter int NSTRIP = STRIPS,
  localparam int AW = $clog2(NSTRIP),
  localparam int SW = AW + PAT_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         full_mode,
  input  logic                         emit,
  input  logic [SW-1:0]                word,
  output logic [MAX_SLOTS-1:0][SW-1:0] slots,
  output logic                         overflow
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;
  logic             room;

  assign limit = slot_limit(full_mode);
  assign room  = count < limit;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (emit) begin
      if (room) count <= count + 1'b1;
      else      overflow <= 1'b1;
    end
  end

  for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clear)
        slots[g] <= '1;
      else if (emit && room && count == CNT_W'(g))
        slots[g] <= word;
    end
  end

  // R8: the fill level never passes the mode's slot count
  assert_slot_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= limit);

  // R8: a cluster arriving with no room left raises overflow
  assert_overflow_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !room && !clear) |=> overflow);

  // R7: overflow stays clear while slots remain free
  assert_no_early_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clear) |-> (count == limit));
endmodule

// File: rtl/strip_cluster_compressor.sv
module strip_cluster_compressor
  import scc_pkg::*;
#(
  parameter int NSTRIP  = STRIPS,
  parameter int TRIG_W  = 8,
  parameter int BUNCH_W = 8,
  localparam int AW    = $clog2(NSTRIP),
  localparam int SW    = AW + PAT_W,
  localparam int PAY_W = 2 + TRIG_W + BUNCH_W + FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               full_mode,
  input  logic [NSTRIP-1:0]  hits,
  input  logic [TRIG_W-1:0]  trig_id,
  input  logic [BUNCH_W-1:0] bunch_id,
  output logic               valid,
  output logic [PAY_W-1:0]   payload
);
  logic                         accept, step, finish;
  logic [AW-1:0]                idx;
  logic [NSTRIP-1:0]            hreg;
  logic                         mode_q;
  logic [TRIG_W-1:0]            trig_q;
  logic [BUNCH_W-1:0]           bunch_q;
  logic                         emit;
  logic [SW-1:0]                word;
  logic [MAX_SLOTS-1:0][SW-1:0] slots;
  logic                         overflow;
  logic [FAST_FW-1:0]           field_fast;
  logic [FULL_FW-1:0]           field_full;
  logic [FIELD_W-1:0]           field;

  scan_sequencer #(.NSTRIP(NSTRIP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(accept), .step(step), .finish(finish), .idx(idx)
  );

  // Captured event; the hit copy shifts so the strip under test sits on top.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hreg    <= '0;
      mode_q  <= 1'b0;
      trig_q  <= '0;
      bunch_q <= '0;
    end else if (accept) begin
      hreg    <= hits;
      mode_q  <= full_mode;
      trig_q  <= trig_id;
      bunch_q <= bunch_id;
    end else if (step) begin
      hreg <= {hreg[NSTRIP-2:0], 1'b0};
    end
  end

  run_scanner #(.NSTRIP(NSTRIP)) u_scan (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step(step),
    .full_mode(mode_q), .idx(idx),
    .cur(hreg[NSTRIP-1]), .nbr(hreg[NSTRIP-2 -: PAT_W]),
    .emit(emit), .word(word)
  );

  slot_collector #(.NSTRIP(NSTRIP)) u_slots (
    .clk(clk), .rst_n(rst_n), .clear(accept), .full_mode(mode_q),
    .emit(emit), .word(word), .slots(slots), .overflow(overflow)
  );

  for (genvar g = 0; g < FAST_SLOTS; g++) begin : g_fast
    assign field_fast[(FAST_SLOTS-g)*AW-1 -: AW] = slots[g][SW-1 -: AW];
  end
  for (genvar g = 0; g < FULL_SLOTS; g++) begin : g_full
    assign field_full[(FULL_SLOTS-g)*SW-1 -: SW] = slots[g];
  end
  assign field = mode_q ? FIELD_W'(field_full) : FIELD_W'(field_fast);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      payload <= '0;
    end else begin
      valid <= finish;
      if (finish) payload <= {mode_q, trig_q, bunch_q, overflow, field};
    end
  end

  // R2: a summary only follows the final scan step
  assert_valid_after_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(finish));

  // R2: the delivered payload is held between summaries
  assert_payload_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !$past(finish)) |-> $stable(payload));
endmodule

// File: tb/strip_cluster_compressor_bench.sv
module strip_cluster_compressor_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         full_mode = 1'b0;
  logic [255:0] hits = '0;
  logic [7:0]   trig_id = '0;
  logic [7:0]   bunch_id = '0;
  logic         valid;
  logic [50:0]  payload;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  strip_cluster_compressor u_strip_cluster_compressor (
    .clk(clk), .rst_n(rst_n), .start(start), .full_mode(full_mode),
    .hits(hits), .trig_id(trig_id), .bunch_id(bunch_id),
    .valid(valid), .payload(payload)
  );

  task automatic check(input bit ok, input string req, input logic [50:0] act,
                       input logic [50:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model: runs found by their edges, windows by stepping four.
  function automatic logic [50:0] model(input logic [255:0] h, input bit m,
                                        input logic [7:0] t, input logic [7:0] b);
    logic [32:0] f;
    bit ov = 0;
    int n = 0;
    int hi = 0;
    int i;
    f = '1;
    if (!m) begin
      f[32] = 1'b0;
      for (int k = 255; k >= 0; k--) begin
        if (h[k] && (k == 255 || !h[k+1])) hi = k;
        if (h[k] && (k == 0 || !h[k-1])) begin
          if (n < 4) f[31-8*n -: 8] = 8'((hi + k) / 2);
          else ov = 1;
          n++;
        end
      end
    end else begin
      i = 255;
      while (i >= 0) begin
        if (h[i]) begin
          logic [2:0] p;
          p[2] = (i >= 1) ? h[i-1] : 1'b0;
          p[1] = (i >= 2) ? h[i-2] : 1'b0;
          p[0] = (i >= 3) ? h[i-3] : 1'b0;
          if (n < 3) f[32-11*n -: 11] = {8'(i), p};
          else ov = 1;
          n++;
          i -= 4;
        end else i--;
      end
    end
    return {m, t, b, ov, f};
  endfunction

  // Start one event, wait for the summary, return edge count and payload.
  task automatic run_event(input logic [255:0] h, input bit m, input logic [7:0] t,
                           input logic [7:0] b, output int lat, output logic [50:0] res);
    @(negedge clk);
    hits = h; full_mode = m; trig_id = t; bunch_id = b; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); #1 lat++;
    end while (!valid && lat < 400);
    res = payload;
  endtask

  task automatic expect_event(input logic [255:0] h, input bit m, input logic [7:0] t,
                              input logic [7:0] b, input string req,
                              output logic [50:0] res);
    int lat;
    logic [50:0] exp;
    exp = model(h, m, t, b);
    run_event(h, m, t, b, lat, res);
    check(lat == 257, "R2 latency", 51'(lat), 51'd257);
    check(res == exp, req, res, exp);
  endtask

  task automatic t_reset;
    check(valid == 1'b0, "R1 valid", 51'(valid), 51'd0);
    check(payload == '0, "R1 payload", payload, '0);
  endtask

  task automatic t_fast_basic;
    logic [255:0] h = '0;
    logic [50:0] r;
    h[250:247] = '1; h[200] = 1'b1; h[100:99] = '1;
    expect_event(h, 1'b0, 8'h3C, 8'hA5, "R5 fast", r);
    check(r[31:0] == {8'd248, 8'd200, 8'd99, 8'hFF}, "R5 fast slots", r, 51'h0F8C863FF);
    check(r[50:33] == {1'b0, 8'h3C, 8'hA5, 1'b0}, "R4 header", r, '0);
    check(r[7:0] == 8'hFF && !r[32], "R7 empty slot", r, '0);
  endtask

  task automatic t_full_basic;
    logic [255:0] h = '0;
    logic [50:0] r;
    h[255] = 1'b1; h[253] = 1'b1; h[40] = 1'b1; h[39] = 1'b1;
    expect_event(h, 1'b1, 8'h11, 8'h22, "R6 full", r);
    check(r[32:0] == {8'd255, 3'b010, 8'd40, 3'b100, 11'h7FF}, "R6 full slots", r, '0);
    check(r[50] == 1'b1 && r[33] == 1'b0, "R4 mode/R7 ovf", r, '0);
  endtask

  task automatic t_edges;
    logic [255:0] h = '0;
    logic [50:0] r;
    h[255:252] = '1; h[1:0] = '1;
    expect_event(h, 1'b0, 8'h01, 8'h02, "R9 fast edges", r);
    check(r[31:16] == {8'd253, 8'd0}, "R9 fast 255/0", r, '0);
    expect_event(h, 1'b1, 8'h01, 8'h02, "R9 full edges", r);
    check(r[32:11] == {8'd255, 3'b111, 8'd1, 3'b100}, "R9 full 255/1", r, '0);
  endtask

  task automatic t_overflow;
    logic [255:0] h = '0;
    logic [50:0] r;
    for (int k = 0; k < 6; k++) h[10*k + 5] = 1'b1;
    expect_event(h, 1'b0, 8'h55, 8'h66, "R8 fast overflow", r);
    check(r[33] == 1'b1 && r[31:24] == 8'd55, "R8 fast keep first", r, '0);
    expect_event(h, 1'b1, 8'h55, 8'h66, "R8 full overflow", r);
    check(r[33] == 1'b1 && r[32:25] == 8'd55, "R8 full keep first", r, '0);
    expect_event('1, 1'b0, 8'h77, 8'h88, "R5 all hit one run", r);
    check(r[33:24] == {1'b0, 8'd127}, "R5 whole run centre", r, '0);
    expect_event('1, 1'b1, 8'h77, 8'h88, "R8 all hit full", r);
  endtask

  task automatic t_empty;
    logic [50:0] r;
    expect_event('0, 1'b1, 8'h9A, 8'hBC, "R7 empty full", r);
    check(r[33:0] == {1'b0, 33'h1FFFFFFFF}, "R7 full all empty", r, '0);
  endtask

  task automatic t_busy_ignore;
    logic [255:0] h = '0;
    logic [255:0] h2 = '1;
    logic [50:0] exp, r;
    int lat = 0;
    int pulses = 0;
    h[30:28] = '1;
    exp = model(h, 1'b0, 8'hC1, 8'hD2);
    @(negedge clk);
    hits = h; full_mode = 1'b0; trig_id = 8'hC1; bunch_id = 8'hD2; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    hits = h2; full_mode = 1'b1; trig_id = 8'h00; bunch_id = 8'h00;
    for (int c = 1; c <= 300; c++) begin
      if (c == 100) start = 1'b1;
      if (c == 101) start = 1'b0;
      @(posedge clk); #1;
      if (valid) begin
        pulses++;
        if (pulses == 1) begin lat = c; r = payload; end
      end
    end
    check(lat == 257, "R3 first summary latency", 51'(lat), 51'd257);
    check(pulses == 1, "R3 single pulse", 51'(pulses), 51'd1);
    check(r == exp, "R10 inputs held at start", r, exp);
    check(payload == exp, "R2 payload held", payload, exp);
  endtask

  task automatic t_back_to_back;
    logic [255:0] h1 = '0;
    logic [255:0] h2 = '0;
    logic [50:0] e1, e2, r1, hold;
    int lat;
    h1[120:118] = '1; h2[60] = 1'b1; h2[58] = 1'b1;
    e1 = model(h1, 1'b0, 8'h10, 8'h20);
    e2 = model(h2, 1'b1, 8'h30, 8'h40);
    run_event(h1, 1'b0, 8'h10, 8'h20, lat, r1);
    check(r1 == e1, "R5 first of pair", r1, e1);
    // Start driven while valid is high for the first summary.
    hits = h2; full_mode = 1'b1; trig_id = 8'h30; bunch_id = 8'h40; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    hold = payload;
    check(valid == 1'b0 && hold == e1, "R2 pulse width/hold", hold, e1);
    lat = 0;
    do begin @(posedge clk); #1 lat++; end while (!valid && lat < 400);
    check(lat == 257, "R2 back-to-back latency", 51'(lat), 51'd257);
    check(payload == e2, "R6 second of pair", payload, e2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_fast_basic();
    t_full_basic();
    t_edges();
    t_overflow();
    t_empty();
    t_busy_ignore();
    t_back_to_back();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule